// File: doc/BRIEF.md
# Delay-Slot Fault Classifier

This block sits beside the main instruction decoder. For every decoded instruction it decides whether that instruction raises a trap, an illegal-slot fault, a general illegal-opcode fault, or nothing. The decoder supplies a valid strobe and a set of attribute flags for each instruction: undefined opcode, DSP-format encoding, writes the program counter, delayed branch, and trap. It also supplies the trap vector, the instruction's own address, the address of the next instruction, and the branch target of a delayed branch.

The classifier keeps a one-bit record of whether the current instruction sits in the slot right after a delayed branch. It also keeps the target that the branch captured. An undefined opcode or a PC-writing instruction found in that slot is reported as an illegal-slot fault, and the captured branch target is given as the return address. The same undefined opcode found outside a slot is reported as a general illegal fault. Undefined opcodes in DSP encodings raise no fault of either kind. The result is combinational and is valid in the same cycle as the decode strobe, so the exception sequencer can act on it at the next edge.

Top module: `slot_fault_classifier`

## Requirements
- R1: After synchronous reset the slot flag is clear, so an undefined non-DSP opcode decoded first reports kind 2'b11, not 2'b10.
- R2: A valid delayed branch puts the next valid instruction in a slot. Any valid instruction that is not a delayed branch ends the slot. Cycles without a valid strobe leave the slot state unchanged, however many there are. A delayed branch that sits in a slot also opens a new slot.
- R3: An asserted flush clears the slot state at the next edge. Flush wins over a delayed branch in the same cycle.
- R4: An undefined opcode with the DSP flag low, decoded in a slot, reports kind 2'b10 (illegal slot).
- R5: An instruction in a slot that writes the PC reports kind 2'b10. This covers the PC-write flag, the delayed-branch flag and the trap flag, whether or not the opcode is undefined.
- R6: An undefined opcode with the DSP flag low, decoded outside a slot, reports kind 2'b11, and the return address is the instruction's own address.
- R7: An undefined opcode with the DSP flag high raises no fault, in a slot or outside one. It can still fault in a slot through R5 when it also writes the PC.
- R8: A trap outside a slot reports kind 2'b01, with the trap vector on the vector output and the next-instruction address as the return address. An undefined non-DSP flag on the same instruction takes precedence and gives 2'b11.
- R9: For an illegal-slot fault, the return address is the target presented with the most recent valid delayed branch.
- R10: The request is high only in a cycle with the valid strobe and a kind other than 2'b00. When no fault is raised, the kind is 2'b00 and both the return address and the vector outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush; clears slot state |
| dec_valid | input | 1 | Decoded instruction present this cycle |
| dec_undef | input | 1 | Opcode is undefined |
| dec_dsp | input | 1 | Opcode is in a DSP encoding |
| dec_pcwr | input | 1 | Instruction writes the PC |
| dec_delayed | input | 1 | Instruction is a delayed branch |
| dec_trap | input | 1 | Instruction is a trap |
| dec_vector | input | VEC_W | Trap vector number |
| dec_pc | input | PC_W | Address of this instruction |
| dec_next_pc | input | PC_W | Address of the following instruction |
| dec_target | input | PC_W | Target of a delayed branch |
| exc_req | output | 1 | Fault request, same cycle as dec_valid |
| exc_kind | output | 2 | 00 none, 01 trap, 10 illegal slot, 11 general illegal |
| exc_vector | output | VEC_W | Trap vector when kind is 01, else 0 |
| exc_ret_pc | output | PC_W | Return address for the reported fault, else 0 |

## Verification
Request, kind, vector and return address are all combinational from the decode inputs and the slot register. They are due in the same cycle as the strobe. The bench drives inputs on the falling edge and samples a quarter period later, before the rising edge that updates the slot state. The slot state set by an instruction only shows in the result of the next valid instruction, one or more edges later. The bench keeps its own slot and target model, which it advances only at rising edges, so every expectation uses the state due at that cycle.

// File: rtl/slot_fault_pkg.sv
package slot_fault_pkg;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'b00,
        EXC_TRAP    = 2'b01,
        EXC_SLOT    = 2'b10,
        EXC_ILLEGAL = 2'b11
    } exc_kind_e;

    typedef struct packed {
        logic undef;
        logic dsp;
        logic pcwr;
        logic delayed;
        logic trap;
    } insn_attr_t;

    // Undefined opcode that is eligible for a fault (DSP encodings exempt)
    function automatic logic is_real_undef(insn_attr_t a);
        return a.undef & ~a.dsp;
    endfunction

    // Any instruction that changes the program counter
    function automatic logic is_pc_writer(insn_attr_t a);
        return a.pcwr | a.delayed | a.trap;
    endfunction

    function automatic exc_kind_e classify(insn_attr_t a, logic in_slot);
        exc_kind_e k;
        k = EXC_NONE;
        if (in_slot) begin
            if (is_real_undef(a) || is_pc_writer(a))
                k = EXC_SLOT;
        end else begin
            if (is_real_undef(a))
                k = EXC_ILLEGAL;
            else if (a.trap)
                k = EXC_TRAP;
        end
        return k;
    endfunction

endpackage

// File: rtl/slot_tracker.sv
module slot_tracker #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            valid,
    input  logic            delayed,
    input  logic [PC_W-1:0] target,
    output logic            in_slot,
    output logic [PC_W-1:0] slot_target
);

    logic            slot_q;
    logic [PC_W-1:0] target_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= 1'b0;
            target_q <= '0;
        end else begin
            if (flush)
                slot_q <= 1'b0;
            else if (valid)
                slot_q <= delayed;
            if (valid && delayed)
                target_q <= target;
        end
    end

    assign in_slot     = slot_q;
    assign slot_target = target_q;

    AST_SLOT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (valid && delayed && !flush) |=> in_slot); // R2
    AST_SLOT_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (valid && !delayed) |=> !in_slot); // R2
    AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!valid && !flush) |=> $stable(in_slot)); // R2
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> !in_slot); // R3
    AST_TARGET_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (valid && delayed) |=> slot_target == $past(target)); // R9

endmodule

// File: rtl/fault_classifier.sv
module fault_classifier
    import slot_fault_pkg::*;
(
    input  logic       valid,
    input  insn_attr_t attr,
    input  logic       in_slot,
    output logic       req,
    output exc_kind_e  kind
);

    always_comb begin
        kind = EXC_NONE;
        if (valid)
            kind = classify(attr, in_slot);
        req = (kind != EXC_NONE);
    end

endmodule

// File: rtl/return_select.sv
module return_select
    import slot_fault_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int VEC_W = 8
) (
    input  exc_kind_e        kind,
    input  logic [PC_W-1:0]  slot_target,
    input  logic [PC_W-1:0]  this_pc,
    input  logic [PC_W-1:0]  next_pc,
    input  logic [VEC_W-1:0] vector_in,
    output logic [PC_W-1:0]  ret_pc,
    output logic [VEC_W-1:0] vector_out
);

    always_comb begin
        ret_pc     = '0;
        vector_out = '0;
        unique case (kind)
            EXC_SLOT:    ret_pc = slot_target;
            EXC_ILLEGAL: ret_pc = this_pc;
            EXC_TRAP: begin
                ret_pc     = next_pc;
                vector_out = vector_in;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/slot_fault_classifier.sv
module slot_fault_classifier
    import slot_fault_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             dec_valid,
    input  logic             dec_undef,
    input  logic             dec_dsp,
    input  logic             dec_pcwr,
    input  logic             dec_delayed,
    input  logic             dec_trap,
    input  logic [VEC_W-1:0] dec_vector,
    input  logic [PC_W-1:0]  dec_pc,
    input  logic [PC_W-1:0]  dec_next_pc,
    input  logic [PC_W-1:0]  dec_target,
    output logic             exc_req,
    output logic [1:0]       exc_kind,
    output logic [VEC_W-1:0] exc_vector,
    output logic [PC_W-1:0]  exc_ret_pc
);

    insn_attr_t      attr;
    logic            in_slot;
    logic [PC_W-1:0] slot_target;
    exc_kind_e       kind;

    assign attr = '{undef: dec_undef, dsp: dec_dsp, pcwr: dec_pcwr,
                    delayed: dec_delayed, trap: dec_trap};

    slot_tracker #(.PC_W(PC_W)) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .valid      (dec_valid),
        .delayed    (dec_delayed),
        .target     (dec_target),
        .in_slot    (in_slot),
        .slot_target(slot_target)
    );

    fault_classifier u_classify (
        .valid  (dec_valid),
        .attr   (attr),
        .in_slot(in_slot),
        .req    (exc_req),
        .kind   (kind)
    );

    return_select #(.PC_W(PC_W), .VEC_W(VEC_W)) u_retsel (
        .kind       (kind),
        .slot_target(slot_target),
        .this_pc    (dec_pc),
        .next_pc    (dec_next_pc),
        .vector_in  (dec_vector),
        .ret_pc     (exc_ret_pc),
        .vector_out (exc_vector)
    );

    assign exc_kind = kind;

    AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> dec_valid); // R10
    AST_DSP_EXEMPT: assert property (@(posedge clk) disable iff (rst)
        (dec_undef && dec_dsp && !dec_pcwr && !dec_delayed && !dec_trap) |-> !exc_req); // R7
    AST_TRAP_NOT_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        (exc_kind == 2'b01) |-> !in_slot); // R8
    AST_SLOT_RETURN: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_kind == 2'b10) |-> exc_ret_pc == slot_target); // R9
    AST_PLAIN_SLOT_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && in_slot && dec_undef && !dec_dsp) |-> exc_kind == 2'b10); // R4

endmodule

// File: tb/slot_fault_classifier_test.sv
module slot_fault_classifier_test;

    localparam int PC_W  = 32;
    localparam int VEC_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             dec_valid = 1'b0;
    logic             dec_undef = 1'b0;
    logic             dec_dsp = 1'b0;
    logic             dec_pcwr = 1'b0;
    logic             dec_delayed = 1'b0;
    logic             dec_trap = 1'b0;
    logic [VEC_W-1:0] dec_vector = '0;
    logic [PC_W-1:0]  dec_pc = '0;
    logic [PC_W-1:0]  dec_next_pc = '0;
    logic [PC_W-1:0]  dec_target = '0;
    logic             exc_req;
    logic [1:0]       exc_kind;
    logic [VEC_W-1:0] exc_vector;
    logic [PC_W-1:0]  exc_ret_pc;

    int checks = 0;
    int fails  = 0;
    logic            m_slot = 1'b0;
    logic [PC_W-1:0] m_target = '0;
    logic [PC_W-1:0] pc_ctr = 32'h0000_0400;

    always #10 clk = ~clk;

    slot_fault_classifier #(.PC_W(PC_W), .VEC_W(VEC_W)) uut (
        .clk(clk), .rst(rst), .flush(flush), .dec_valid(dec_valid),
        .dec_undef(dec_undef), .dec_dsp(dec_dsp), .dec_pcwr(dec_pcwr),
        .dec_delayed(dec_delayed), .dec_trap(dec_trap), .dec_vector(dec_vector),
        .dec_pc(dec_pc), .dec_next_pc(dec_next_pc), .dec_target(dec_target),
        .exc_req(exc_req), .exc_kind(exc_kind), .exc_vector(exc_vector),
        .exc_ret_pc(exc_ret_pc)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check before the rising edge,
    // then advance the model at the rising edge.
    task automatic step(logic v, logic [4:0] f, logic fl, string tag);
        logic rund, pw;
        logic [1:0] ek;
        logic [PC_W-1:0] er;
        logic [VEC_W-1:0] ev;
        @(negedge clk);
        dec_valid = v;
        {dec_undef, dec_dsp, dec_pcwr, dec_delayed, dec_trap} = f;
        flush = fl;
        dec_pc = pc_ctr;
        dec_next_pc = pc_ctr + 2;
        dec_target = 32'h0000_8000 + {pc_ctr[15:0], 4'h0};
        dec_vector = pc_ctr[7:0] ^ 8'h5A;
        pc_ctr = pc_ctr + 2;
        #5;
        rund = f[4] & ~f[3];
        pw = f[2] | f[1] | f[0];
        ek = 2'b00;
        if (v) begin
            if (m_slot) ek = (rund || pw) ? 2'b10 : 2'b00;
            else if (rund) ek = 2'b11;
            else if (f[0]) ek = 2'b01;
        end
        er = (ek == 2'b10) ? m_target : (ek == 2'b11) ? dec_pc :
             (ek == 2'b01) ? dec_next_pc : '0;
        ev = (ek == 2'b01) ? dec_vector : '0;
        check({tag, " kind"}, 64'(exc_kind), 64'(ek));
        check({tag, " req"}, 64'(exc_req), 64'(ek != 2'b00));
        check({tag, " ret_pc"}, 64'(exc_ret_pc), 64'(er));
        check({tag, " vector"}, 64'(exc_vector), 64'(ev));
        @(posedge clk);
        if (v && f[1]) m_target = dec_target;
        if (fl) m_slot = 1'b0;
        else if (v) m_slot = f[1];
    endtask

    // flag order {undef, dsp, pcwr, delayed, trap}
    localparam logic [4:0] F_NOP = 5'b00000;
    localparam logic [4:0] F_BR  = 5'b00110;
    localparam logic [4:0] F_UND = 5'b10000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: first instruction after reset is outside a slot
        step(1'b1, F_UND, 1'b0, "R1 reset state");

        // Sweep all flag combinations outside and inside a slot (R4 R5 R6 R7 R8 R10)
        for (int ctx = 0; ctx < 2; ctx++) begin
            for (int c = 0; c < 32; c++) begin
                step(1'b1, F_NOP, 1'b0, "R10 clear slot");
                if (ctx == 1) step(1'b1, F_BR, 1'b0, "R2 open slot");
                step(1'b1, 5'(c), 1'b0,
                     (ctx == 1) ? "R4 R5 R7 R9 in slot" : "R6 R7 R8 outside slot");
            end
        end

        // R2 and R9: idle cycles keep the slot and captured target
        step(1'b1, F_NOP, 1'b0, "R2 clear");
        step(1'b1, F_BR, 1'b0, "R2 branch");
        for (int k = 0; k < 4; k++) step(1'b0, F_UND, 1'b0, "R10 idle no request");
        step(1'b1, F_UND, 1'b0, "R9 slot after gap");

        // R2: a branch in a slot opens another slot with its own target
        step(1'b1, F_BR, 1'b0, "R2 first branch");
        step(1'b1, F_BR, 1'b0, "R5 branch in slot");
        step(1'b1, F_UND, 1'b0, "R9 second target");
        step(1'b1, F_UND, 1'b0, "R2 slot closed");

        // R3: flush clears the slot, and beats a branch in the same cycle
        step(1'b1, F_BR, 1'b0, "R3 branch");
        step(1'b0, F_NOP, 1'b1, "R3 flush idle");
        step(1'b1, F_UND, 1'b0, "R3 after flush");
        step(1'b1, F_BR, 1'b1, "R3 branch with flush");
        step(1'b1, 5'b00001, 1'b0, "R3 trap after flushed branch");

        // R7: DSP undefined in a slot, no fault
        step(1'b1, F_BR, 1'b0, "R7 branch");
        step(1'b1, 5'b11000, 1'b0, "R7 dsp undefined in slot");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule